// File: doc/BRIEF.md
# Single-Channel PWM Generator with Full-Scale Duty Handling

This block produces one pulse-width modulated output from a free-running 16-bit time base. The time base advances once per PWM clock enable, a single-cycle tick supplied from an external prescaler. A period value sets the number of ticks in one output cycle, and a pulse value sets how many ticks of that cycle the internal level stays high. A period value of zero selects the full 65536-tick range.

Software loads both values through a one-cycle write strobe with a select bit. Each write lands in a shadow copy, and the shadow copies move into the working copies only when a new period begins. Duty and period changes, including entering or leaving the 0% and 100% states, are therefore applied cleanly at a period boundary while the counter keeps running. A pulse value of zero holds the level low for good. A pulse value equal to or above a nonzero period holds it high for good. A polarity input inverts the final output. When the enable input is low the output rests at its inactive level. The first tick after enable returns starts a fresh period with the latest shadow values.

Top module: `pwm_chan`

## Requirements
- R1: After a synchronous active-low reset, with enable low and invert low, `pwm_out` is 0, and both the period and pulse values read as zero.
- R2: The counter advances only on cycles where `tick` is 1. A nonzero period value P gives an output cycle of exactly P ticks. When `tick` arrives every third clock, any 765 consecutive clocks hold exactly 6 high clocks for P=255 and W=2.
- R3: With pulse value W where 0 < W < P, the level is high for the first W ticks of each period and low for the rest. For P=255 and W=2, any window of 255 ticks contains exactly 2 high ticks.
- R4: A pulse value of 0 keeps the internal level low in every period. With invert low, `pwm_out` stays 0.
- R5: With P nonzero and W >= P, the level stays high across every period boundary without a single low cycle. Entering or leaving this state takes effect only at a period start.
- R6: A period value of 0 gives a 65536-tick period. With W = 0xFFFF, the level is high for 65535 ticks and low for 1 tick in each period.
- R7: A write with `wr_en`=1 stores `wr_data` into the period shadow when `wr_sel`=0, or into the pulse shadow when `wr_sel`=1. Shadow values reach the output only from the next period start. A write in the same cycle as a period start is applied one period later.
- R8: `pwm_out` is the internal level XORed with `invert`. With invert high, P=255 and W=2 give 253 high ticks per period.
- R9: While `enable` is 0, the counter and the internal level are held at 0, so `pwm_out` equals `invert`. The first tick after `enable` returns to 1 starts a new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Channel run enable; low parks the output at its inactive level |
| tick | input | 1 | PWM clock enable from the external prescaler |
| wr_en | input | 1 | Shadow register write strobe |
| wr_sel | input | 1 | Write target: 0 = period, 1 = pulse |
| wr_data | input | 16 | Value to store into the selected shadow register |
| invert | input | 1 | Output polarity: 1 inverts the final output |
| pwm_out | output | 1 | Modulated output |

## Verification
The internal level is a register, so any change caused by a tick shows on `pwm_out` in the cycle after that tick is sampled. A change of `invert` passes through combinationally in the same cycle. The bench updates its behavioural model at each rising edge from inputs that were driven at the previous falling edge. It then compares the output one nanosecond after the edge, so both the one-cycle latency and the same-cycle polarity path are tested on every clock. Duty checks count high samples over windows that are exactly one period long, and they begin only after enough cycles have passed for a reload to have applied the new values.

// File: rtl/pwm_pkg.sv
// pwm_pkg: shared definitions for the PWM channel.
// Assumes a single channel with two software-visible values (period, pulse).
package pwm_pkg;

    // Number of double-buffered values held by the channel.
    localparam int unsigned REG_COUNT = 2;

    // Write selector encoding used on wr_sel.
    typedef enum logic [0:0] {
        SEL_PERIOD = 1'b0,
        SEL_PULSE  = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/pwm_dbuf.sv
// pwm_dbuf: shadow/working register pairs.
// A write lands in the shadow copy of the selected entry. On 'load' every
// working copy takes the shadow value it held before that clock edge.
// Assumes a write and a load in the same cycle: the load sees the old shadow.
module pwm_dbuf #(
    parameter int unsigned DW = 16,
    parameter int unsigned N  = 2,
    localparam int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [SW-1:0]   wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic            load,
    output logic [N*DW-1:0] shadow_flat,
    output logic [N*DW-1:0] work_flat
);

    for (genvar g = 0; g < N; g++) begin : g_entry
        logic [DW-1:0] shadow_q;
        logic [DW-1:0] work_q;

        // Capture software writes addressed to this entry.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow_q <= '0;
            else if (wr_en && (wr_idx == SW'(g)))
                shadow_q <= wr_data;
        end

        // Promote the shadow value at a period start.
        always_ff @(posedge clk) begin
            if (!rst_n)
                work_q <= '0;
            else if (load)
                work_q <= shadow_q;
        end

        assign shadow_flat[g*DW +: DW] = shadow_q;
        assign work_flat[g*DW +: DW]   = work_q;
    end

endmodule

// File: rtl/pwm_timebase.sv
// pwm_timebase: up counter giving the tick offset within the current period.
// Counts 0 .. P-1 on ticks; P = 0 means the full 2**CW range because the
// last offset is computed as P-1 modulo 2**CW. The first tick after enable
// (or reset) is a period start. Disabled: counter parked at zero.
module pwm_timebase #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          tick,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] count,
    output logic          reload,
    output logic          start_pend
);

    logic [CW-1:0] last_off;
    logic          at_last;

    // Offset of the final tick in the working period (wraps for zero).
    assign last_off = period - CW'(1);
    assign at_last  = (count == last_off);
    assign reload   = enable && tick && (start_pend || at_last);

    // Counter: restart on reload, step on other ticks, park when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            count <= '0;
        else if (reload)
            count <= '0;
        else if (tick)
            count <= count + CW'(1);
    end

    // Remember that the next tick must open a fresh period.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            start_pend <= 1'b1;
        else if (reload)
            start_pend <= 1'b0;
    end

endmodule

// File: rtl/pwm_level.sv
// pwm_level: output flip-flop and polarity stage.
// Sets at a period start unless the incoming pulse value is zero; clears
// when the next offset equals the working pulse value unless the channel is
// at full scale. Assumes count stays below a nonzero period.
module pwm_level #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          tick,
    input  logic          reload,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] work_per,
    input  logic [CW-1:0] work_pw,
    input  logic [CW-1:0] next_pw,
    input  logic          invert,
    output logic          level,
    output logic          pwm_out
);

    logic [CW:0] next_off;
    logic        full_scale;
    logic        hit_width;

    // Offset the counter will show after this tick.
    assign next_off   = {1'b0, count} + (CW+1)'(1);
    // Width at or past a nonzero period: never clear inside the period.
    assign full_scale = (work_per != '0) && (work_pw >= work_per);
    assign hit_width  = (next_off == {1'b0, work_pw}) && !full_scale;

    // Output flip-flop: set at period start, clear at width match.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            level <= 1'b0;
        else if (reload)
            level <= (next_pw != '0);
        else if (tick && hit_width)
            level <= 1'b0;
    end

    // Polarity selection on the final output.
    assign pwm_out = level ^ invert;

endmodule

// File: rtl/pwm_chan.sv
// pwm_chan: single-channel PWM generator with double-buffered period and
// pulse values, 0% / 100% handling and output polarity.
// Assumes 'tick' is a one-cycle enable from an external prescaler.
module pwm_chan
    import pwm_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          tick,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [CW-1:0] wr_data,
    input  logic          invert,
    output logic          pwm_out
);

    localparam int unsigned NREG = REG_COUNT;
    localparam int unsigned SELW = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int unsigned IDX_PER = int'(SEL_PERIOD);
    localparam int unsigned IDX_PW  = int'(SEL_PULSE);

    logic [NREG*CW-1:0] shadow_flat;
    logic [NREG*CW-1:0] work_flat;
    logic [CW-1:0]      act_per;
    logic [CW-1:0]      act_pw;
    logic [CW-1:0]      sh_pw;
    logic [CW-1:0]      cnt;
    logic               reload;
    logic               start_pend;
    logic               level_q;
    logic [SELW-1:0]    wr_idx;

    assign wr_idx  = SELW'(wr_sel);
    assign act_per = work_flat[IDX_PER*CW +: CW];
    assign act_pw  = work_flat[IDX_PW*CW +: CW];
    assign sh_pw   = shadow_flat[IDX_PW*CW +: CW];

    pwm_dbuf #(.DW(CW), .N(NREG)) u_dbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .load       (reload),
        .shadow_flat(shadow_flat),
        .work_flat  (work_flat)
    );

    pwm_timebase #(.CW(CW)) u_tbase (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (tick),
        .period    (act_per),
        .count     (cnt),
        .reload    (reload),
        .start_pend(start_pend)
    );

    pwm_level #(.CW(CW)) u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .tick    (tick),
        .reload  (reload),
        .count   (cnt),
        .work_per(act_per),
        .work_pw (act_pw),
        .next_pw (sh_pw),
        .invert  (invert),
        .level   (level_q),
        .pwm_out (pwm_out)
    );

endmodule

// File: rtl/pwm_chan_chk.sv
// pwm_chan_chk: temporal checks on the PWM channel, bound to pwm_chan.
module pwm_chan_chk #(
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          tick,
    input logic          invert,
    input logic          pwm_out,
    input logic [CW-1:0] cnt,
    input logic          reload,
    input logic          start_pend,
    input logic [CW-1:0] act_per,
    input logic [CW-1:0] act_pw,
    input logic          level_q
);

    // R9
    disabled_parks_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!level_q && cnt == '0))
        else $error("level or counter not parked while disabled");

    // R2
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick) |=> ($stable(cnt) && $stable(level_q)))
        else $error("state moved without a tick");

    // R2
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_per != '0) |-> (cnt < act_per))
        else $error("counter beyond working period");

    // R4
    zero_width_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_pw == '0) |-> !level_q)
        else $error("level high with zero pulse value");

    // R5
    full_scale_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !start_pend && act_per != '0 && act_pw >= act_per) |-> level_q)
        else $error("level low at full scale");

    // R7
    boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> ($stable(act_per) && $stable(act_pw)))
        else $error("working values changed away from a period start");

    // R8
    polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && invert) |=> (pwm_out || !invert))
        else $error("disabled output not at inverted rest level");

endmodule

bind pwm_chan pwm_chan_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .tick      (tick),
    .invert    (invert),
    .pwm_out   (pwm_out),
    .cnt       (cnt),
    .reload    (reload),
    .start_pend(start_pend),
    .act_per   (act_per),
    .act_pw    (act_pw),
    .level_q   (level_q)
);

// File: tb/pwm_chan_test.sv
// pwm_chan_test: behavioural reference model compared on every clock.
module pwm_chan_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic        tick;
    logic        wr_en;
    logic        wr_sel;
    logic [15:0] wr_data;
    logic        invert;
    logic        pwm_out;

    int compared = 0;
    int mismatched = 0;
    string phase = "R1";
    bit done = 0;

    // Reference model state.
    int m_cnt = 0, m_per = 0, m_pw = 0, s_per = 0, s_pw = 0;
    bit m_lvl = 0, m_pend = 1;

    int tick_div = 1;

    always #4 clk = ~clk;

    pwm_chan uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .invert(invert), .pwm_out(pwm_out)
    );

    // Model update at each edge, comparison 1 ns later.
    always @(posedge clk) begin
        int plen;
        if (!rst_n) begin
            m_cnt = 0; m_per = 0; m_pw = 0; s_per = 0; s_pw = 0;
            m_lvl = 0; m_pend = 1;
        end else begin
            if (!enable) begin
                m_cnt = 0; m_lvl = 0; m_pend = 1;
            end else if (tick) begin
                plen = (m_per == 0) ? 65536 : m_per;
                if (m_pend || m_cnt == plen - 1) begin
                    m_per = s_per; m_pw = s_pw; m_cnt = 0;
                    m_lvl = (s_pw != 0); m_pend = 0;
                end else begin
                    m_cnt++;
                    if (m_cnt == m_pw) m_lvl = 0;
                end
            end
            if (wr_en) begin
                if (wr_sel) s_pw = wr_data; else s_per = wr_data;
            end
        end
        #1;
        if (!done) begin
            compared++;
            if (pwm_out !== (m_lvl ^ invert)) begin
                mismatched++;
                $display("FAIL %s: pwm_out=%0b expected %0b at %0t",
                         phase, pwm_out, m_lvl ^ invert, $time);
            end
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 0;
            tick = ((i % tick_div) == 0);
        end
    endtask

    task automatic write_reg(bit sel, int val);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_data = 16'(val);
        tick = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic check_val(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Count high output samples over n consecutive clocks, ticking every tick_div.
    task automatic window(int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 0;
            tick = ((i % tick_div) == 0);
            @(posedge clk);
            #1;
            if (pwm_out) highs++;
        end
    endtask

    initial begin
        int h;
        rst_n = 0; enable = 0; tick = 0; wr_en = 0; wr_sel = 0;
        wr_data = '0; invert = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_val("R1", int'(pwm_out), 0);

        // R3: 255-tick period, 2-tick pulse.
        phase = "R3";
        write_reg(0, 255);
        write_reg(1, 2);
        enable = 1;
        step(300);
        window(255, h);
        check_val("R3", h, 2);

        // R2: tick every third clock.
        phase = "R2";
        tick_div = 3;
        step(300);
        window(765, h);
        check_val("R2", h, 6);
        tick_div = 1;
        step(10);

        // R7: mid-period write must not act before the boundary.
        phase = "R7";
        while (pwm_out !== 1'b1) step(1);
        while (pwm_out !== 1'b0) step(1);
        write_reg(1, 100);
        window(50, h);
        check_val("R7", h, 0);
        step(300);
        window(255, h);
        check_val("R7", h, 100);

        // R4: zero pulse value.
        phase = "R4";
        write_reg(1, 0);
        step(300);
        window(255, h);
        check_val("R4", h, 0);

        // R5: pulse equal to and above period.
        phase = "R5";
        write_reg(1, 255);
        step(300);
        window(255, h);
        check_val("R5", h, 255);
        write_reg(1, 400);
        step(300);
        window(510, h);
        check_val("R5", h, 510);
        write_reg(1, 2);
        step(300);
        window(255, h);
        check_val("R5", h, 2);

        // R8: inverted polarity.
        phase = "R8";
        invert = 1;
        window(255, h);
        check_val("R8", h, 253);

        // R9: disabled output rests at inactive level.
        phase = "R9";
        enable = 0;
        step(10);
        check_val("R9", int'(pwm_out), 1);
        invert = 0;
        step(5);
        check_val("R9", int'(pwm_out), 0);
        write_reg(1, 5);
        enable = 1;
        step(1);
        check_val("R9", int'(pwm_out), 1);
        step(300);
        window(255, h);
        check_val("R9", h, 5);

        // R6: zero period gives 65536 ticks.
        phase = "R6";
        write_reg(0, 0);
        write_reg(1, 16'hFFFF);
        step(300);
        window(65536, h);
        check_val("R6", h, 65535);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        done = 1;
        compared++;
        mismatched++;
        $display("FAIL %s: watchdog expired, got running expected finished", phase);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule